// File: doc/BRIEF.md
# Match-Compare Timer with Settling Flags

A memory-mapped timer with a free-running counter that advances on a tick enable from a slower timer clock. The counter is not read directly. Software asks for a snapshot and then reads a captured copy of the counter. Writes to the counter and to the compare value do not take effect at once. Each one travels into the timer domain over a fixed number of ticks. A per-register busy flag in an access-status register shows when that transfer is still in progress.

An event bit is set when the counter steps onto the compare value, and another when it rolls over. These bits are cleared by writing ones to them. The compare event drives a level interrupt line through an enable bit. The bus side is a single-cycle 32-bit register port. Reads are combinational on the address.

Top module: `mtm_timer`

## Requirements
- R1: After reset the compare register (0x00) reads 0xFFFFFFFF, and these read 0: snapshot (0x10), event status (0x14), interrupt enable (0x1C), control (0x20) and access status (0x24). The interrupt output is low. Unmapped addresses read 0.
- R2: With control bit 0 set, the counter steps by one on each cycle where tick_i is high. With control bit 0 clear, it holds.
- R3: A control write with bit 1 set raises access-status bit 5. On the second following tick the snapshot register captures the counter value present before that edge, and bit 5 drops. Control reads back only bit 0.
- R4: A snapshot request made while access-status bit 5 is high is ignored.
- R5: A write to 0x10 raises access-status bit 4. On the second following tick the counter is loaded with the written value in place of its increment, and bit 4 drops. A write to 0x10 while bit 4 is high is ignored.
- R6: A write to 0x00 raises access-status bit 0. The compare register keeps its old value until the second following tick, when it takes the new one and bit 0 drops. A write to 0x00 while bit 0 is high is ignored.
- R7: Status bit 0 is set on the tick where the incrementing counter becomes equal to the compare value.
- R8: The counter wraps from 0xFFFFFFFF to 0 and sets status bit 1. A compare value just past the wrap still sets status bit 0.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Status bits 3:2 read 0.
- R10: irq_o is status bit 0 AND interrupt-enable bit 0. It is a level that follows both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer-domain tick enable |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high |
| addr_i | input | 8 | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| irq_o | output | 1 | Compare interrupt, level |

## Verification
A register write lands on the clock edge where the strobe is sampled, so readback, the busy flags and irq_o are compared one cycle after the write. A transfer completes on the second tick after it is accepted, so the counter load, the compare update and the snapshot capture are checked only after exactly two tick cycles. A check after one tick confirms the flag is still high. The bench drives a tick alone on its own cycle and keeps it apart from bus writes. This keeps the counter value expected at each edge exact. Each expected item enters the scoreboard queue at the moment its result is due and is compared there.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam logic [7:0] OFF_MATCH = 8'h00;
  localparam logic [7:0] OFF_SNAP  = 8'h10;
  localparam logic [7:0] OFF_STAT  = 8'h14;
  localparam logic [7:0] OFF_IEN   = 8'h1C;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_BUSY  = 8'h24;

  localparam int unsigned BUSY_MATCH_BIT = 0;
  localparam int unsigned BUSY_CNT_BIT   = 4;
  localparam int unsigned BUSY_SNAP_BIT  = 5;

  localparam int unsigned EVT_W = 2;  // bit0 compare, bit1 wrap
endpackage

// File: rtl/mtm_xfer.sv
module mtm_xfer #(
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int unsigned STG_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic             busy_q;
  logic [STG_W-1:0] stg_q;
  logic             last;

  assign last     = (stg_q == STG_W'(LAT - 1));
  assign commit_o = busy_q & tick_i & last;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      stg_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        stg_q  <= '0;
      end
    end else if (tick_i) begin
      if (last) busy_q <= 1'b0;
      else      stg_q  <= stg_q + 1'b1;
    end
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> busy_q);
endmodule

// File: rtl/mtm_counter.sv
module mtm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] match_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             step;

  assign step    = tick_i & run_i & ~load_i;
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign hit_o   = step & (cnt_nxt == match_val_i);
  assign wrap_o  = step & (&cnt_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_nxt;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !load_i) |=> $stable(cnt_q));

  // R5
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/mtm_timer.sv
module mtm_timer
  import mtm_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = 32;

  logic wr, wr_match, wr_cnt, wr_stat, wr_ien, wr_ctrl;
  assign wr       = req_i & we_i;
  assign wr_match = wr & (addr_i == ADDR_W'(OFF_MATCH));
  assign wr_cnt   = wr & (addr_i == ADDR_W'(OFF_SNAP));
  assign wr_stat  = wr & (addr_i == ADDR_W'(OFF_STAT));
  assign wr_ien   = wr & (addr_i == ADDR_W'(OFF_IEN));
  assign wr_ctrl  = wr & (addr_i == ADDR_W'(OFF_CTRL));

  logic m_busy, m_commit, c_busy, c_commit, s_busy, s_commit;

  mtm_xfer #(.LAT(SYNC_TICKS)) u_xfer_match (
    .clk_i, .rst_ni, .tick_i, .start_i(wr_match), .busy_o(m_busy), .commit_o(m_commit));
  mtm_xfer #(.LAT(SYNC_TICKS)) u_xfer_cnt (
    .clk_i, .rst_ni, .tick_i, .start_i(wr_cnt), .busy_o(c_busy), .commit_o(c_commit));
  mtm_xfer #(.LAT(SYNC_TICKS)) u_xfer_snap (
    .clk_i, .rst_ni, .tick_i, .start_i(wr_ctrl & wdata_i[1]), .busy_o(s_busy), .commit_o(s_commit));

  logic [CNT_W-1:0] match_q, match_pend_q, cnt_pend_q, snap_q, cnt;
  logic             run_q, ien_q, hit, wrap;
  logic [EVT_W-1:0] st_q;

  mtm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .tick_i,
    .run_i       (run_q),
    .load_i      (c_commit),
    .load_val_i  (cnt_pend_q),
    .match_val_i (match_q),
    .cnt_o       (cnt),
    .hit_o       (hit),
    .wrap_o      (wrap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q      <= '1;
      match_pend_q <= '0;
      cnt_pend_q   <= '0;
      snap_q       <= '0;
      run_q        <= 1'b0;
      ien_q        <= 1'b0;
    end else begin
      if (wr_match && !m_busy) match_pend_q <= wdata_i[CNT_W-1:0];
      if (wr_cnt && !c_busy)   cnt_pend_q   <= wdata_i[CNT_W-1:0];
      if (m_commit)            match_q      <= match_pend_q;
      if (s_commit)            snap_q       <= cnt;
      if (wr_ctrl)             run_q        <= wdata_i[0];
      if (wr_ien)              ien_q        <= wdata_i[0];
    end
  end

  // event set has priority over a clear in the same cycle
  logic [EVT_W-1:0] evt_set;
  assign evt_set = {wrap, hit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else begin
      for (int i = 0; i < int'(EVT_W); i++) begin
        if (evt_set[i])                 st_q[i] <= 1'b1;
        else if (wr_stat && wdata_i[i]) st_q[i] <= 1'b0;
      end
    end
  end

  assign irq_o = st_q[0] & ien_q;

  logic [DATA_W-1:0] busy_vec;
  always_comb begin
    busy_vec                 = '0;
    busy_vec[BUSY_MATCH_BIT] = m_busy;
    busy_vec[BUSY_CNT_BIT]   = c_busy;
    busy_vec[BUSY_SNAP_BIT]  = s_busy;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_MATCH): rdata_o = DATA_W'(match_q);
      ADDR_W'(OFF_SNAP):  rdata_o = DATA_W'(snap_q);
      ADDR_W'(OFF_STAT):  rdata_o = DATA_W'(st_q);
      ADDR_W'(OFF_IEN):   rdata_o = DATA_W'(ien_q);
      ADDR_W'(OFF_CTRL):  rdata_o = DATA_W'(run_q);
      ADDR_W'(OFF_BUSY):  rdata_o = busy_vec;
      default:            rdata_o = '0;
    endcase
  end

  // R7
  cmp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[0]) |-> $past(hit));

  // R6
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_commit |=> $stable(match_q));

  // R9
  evt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && !hit) |=> !st_q[0]);

  // R3
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_commit |=> $stable(snap_q));
endmodule

// File: tb/mtm_timer_test.sv
`timescale 1ns/1ps
module mtm_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  mtm_timer uut (.*);

  always #2.5 clk_i = ~clk_i;

  localparam logic [7:0] A_MATCH = 8'h00, A_SNAP = 8'h10, A_STAT = 8'h14,
                         A_IEN = 8'h1C, A_CTRL = 8'h20, A_BUSY = 8'h24;

  typedef struct {
    string       req;
    bit          is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  // monitor: pops expected items when their result is due
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      got = it.is_irq ? {31'b0, irq_o} : rdata_o;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h got=%h exp=%h", it.req, it.addr, got, it.exp);
      end
    end
  end

  task automatic expect_rd(string r, logic [7:0] a, logic [31:0] e);
    item_t it;
    addr_i = a;
    #0.5;
    it.req = r; it.is_irq = 0; it.addr = a; it.exp = e;
    q.push_back(it);
    ->chk_ev;
    #0.5;
  endtask

  task automatic expect_irq(string r, logic e);
    item_t it;
    it.req = r; it.is_irq = 1; it.addr = 8'hFF; it.exp = {31'b0, e};
    q.push_back(it);
    ->chk_ev;
    #0.5;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1 tick_i = 1;
      @(posedge clk_i); #1 tick_i = 0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    expect_rd("R1", A_MATCH, 32'hFFFF_FFFF);
    expect_rd("R1", A_SNAP, 0);
    expect_rd("R1", A_STAT, 0);
    expect_rd("R1", A_IEN, 0);
    expect_rd("R1", A_CTRL, 0);
    expect_rd("R1", A_BUSY, 0);
    expect_rd("R1", 8'h04, 0);
    expect_irq("R1", 0);

    bus_wr(A_CTRL, 1);
    ticks(5);                                   // cnt 5
    bus_wr(A_CTRL, 3);
    expect_rd("R3", A_BUSY, 32'h20);
    expect_rd("R3", A_CTRL, 1);
    ticks(1);                                   // cnt 6
    expect_rd("R3", A_BUSY, 32'h20);
    ticks(1);                                   // snap 6, cnt 7
    expect_rd("R3", A_BUSY, 0);
    expect_rd("R2", A_SNAP, 6);

    bus_wr(A_CTRL, 3);
    ticks(1);                                   // cnt 8
    bus_wr(A_CTRL, 3);                          // ignored
    ticks(1);                                   // snap 8, cnt 9
    expect_rd("R4", A_BUSY, 0);
    expect_rd("R4", A_SNAP, 8);

    bus_wr(A_SNAP, 32'h100);
    expect_rd("R5", A_BUSY, 32'h10);
    ticks(1);
    expect_rd("R5", A_BUSY, 32'h10);
    bus_wr(A_SNAP, 32'h555);                    // ignored
    ticks(1);                                   // load 0x100
    expect_rd("R5", A_BUSY, 0);
    bus_wr(A_CTRL, 3);
    ticks(2);                                   // snap 0x101, cnt 0x102
    expect_rd("R5", A_SNAP, 32'h101);

    bus_wr(A_MATCH, 32'h105);
    expect_rd("R6", A_BUSY, 32'h1);
    expect_rd("R6", A_MATCH, 32'hFFFF_FFFF);
    ticks(1);                                   // cnt 0x103
    bus_wr(A_MATCH, 32'h200);                   // ignored
    ticks(1);                                   // commit, cnt 0x104
    expect_rd("R6", A_BUSY, 0);
    expect_rd("R6", A_MATCH, 32'h105);
    expect_rd("R7", A_STAT, 0);
    ticks(1);                                   // cnt 0x105, hit
    expect_rd("R7", A_STAT, 1);
    expect_irq("R10", 0);
    bus_wr(A_IEN, 1);
    expect_irq("R10", 1);
    bus_wr(A_IEN, 0);
    expect_irq("R10", 0);
    expect_rd("R10", A_STAT, 1);
    bus_wr(A_IEN, 1);
    expect_irq("R10", 1);
    bus_wr(A_STAT, 1);
    expect_rd("R9", A_STAT, 0);
    expect_irq("R9", 0);

    bus_wr(A_CTRL, 0);
    ticks(3);
    bus_wr(A_CTRL, 2);
    ticks(2);
    expect_rd("R2", A_SNAP, 32'h105);
    expect_rd("R2", A_CTRL, 0);
    expect_rd("R2", A_STAT, 0);

    bus_wr(A_CTRL, 1);
    bus_wr(A_SNAP, 32'hFFFF_FFFE);
    ticks(2);                                   // cnt 0xFFFFFFFE
    bus_wr(A_MATCH, 1);
    ticks(1);                                   // cnt 0xFFFFFFFF
    ticks(1);                                   // wrap to 0, match=1
    expect_rd("R8", A_STAT, 32'h2);
    expect_irq("R8", 0);
    ticks(1);                                   // cnt 1, hit
    expect_rd("R8", A_STAT, 32'h3);
    expect_irq("R8", 1);
    bus_wr(A_STAT, 32'h2);
    expect_rd("R9", A_STAT, 32'h1);
    expect_irq("R9", 1);
    bus_wr(A_STAT, 32'hF);
    expect_rd("R9", A_STAT, 0);
    expect_irq("R10", 0);
    bus_wr(A_CTRL, 3);
    ticks(2);                                   // snap 2
    expect_rd("R8", A_SNAP, 32'h2);

    #2;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule